// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block holds the interrupt-signalling registers of one core. Other cores reach it through a 32-bit register request channel. A write to the set port turns on pending bits in a status word. A write to the clear port turns pending bits off. An enable word decides which pending bits may assert the core's level interrupt. Eight 32-bit mailbox words, grouped as four two-word mailboxes, carry message data next to the interrupt.

Requests arrive on a valid/ready channel. A request moves when `req_valid` and `req_ready` are both high at a rising clock edge, and it moves one 4-byte access. A write produces no response. A read returns its data on a response channel one cycle after acceptance. The response stays valid, with unchanged data, until `rsp_ready` is high at a rising edge. While a response is waiting, `req_ready` is low, so at most one read is ever outstanding. Writes to the status word pulse `err_illegal`. Accesses to any offset that is not decoded pulse `err_unimpl`.

Top module: `ipi_bank`

## Requirements
- R1: After reset, `irq` is low, `rsp_valid` is low, `req_ready` is high, and the status, enable and mailbox words all read as zero.
- R2: A write to the set port (offset 0x08) ORs the written bits into status. A read of the status word (offset 0x00) returns the current status.
- R3: After a set-port write, `irq` is high in the cycle after acceptance when (new status AND enable) is nonzero. Otherwise `irq` keeps its previous level.
- R4: A write to the clear port (offset 0x0C) removes the written bits from status. In the cycle after acceptance, `irq` is low when the new status is zero and enable is nonzero. Otherwise `irq` keeps its previous level, so it can stay high with zero status while enable is zero.
- R5: A write to the status word leaves status unchanged and pulses `err_illegal` for one cycle after acceptance.
- R6: The enable word (offset 0x04) is written and read back whole. Writing it never changes `irq`.
- R7: Reads of the set port and the clear port return zero.
- R8: Mailbox word k (k = 0..7) sits at byte offset 0x20 + 4k, so the index is (offset − 0x20) >> 2. Each word keeps its own written value.
- R9: Accesses to any other offset, including offsets inside the range that are not 4-byte aligned, change no state. Reads of such offsets return zero. Each such access pulses `err_unimpl` for one cycle after acceptance.
- R10: Read data appears on `rsp_rdata` with `rsp_valid` one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response and its data are held and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the access |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the read response |
| rsp_rdata | output | DATA_W (32) | Read response data |
| err_illegal | output | 1 | One-cycle pulse: status word was written |
| err_unimpl | output | 1 | One-cycle pulse: undecoded offset accessed |
| irq | output | 1 | Registered level interrupt to the core |

## Verification
Status is built up across several set writes and then read back. One pattern is masked by enable and one is not, which separates the OR into status from the decision to assert the interrupt. Clear writes are run with enable nonzero and with enable zero. These show that the interrupt drops only when status empties under a nonzero enable, and that it stays high in the zero-enable case. Mailbox words are written with distinct values and read back in reverse order, which exposes any index aliasing. Misaligned and out-of-range offsets are accessed, and the mailbox and status are then re-read to show that nothing changed. A read issued while `rsp_ready` is held low checks that the response is held and that the request channel is stalled.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;
  localparam int unsigned OFF_STATUS = 32'h00;
  localparam int unsigned OFF_ENABLE = 32'h04;
  localparam int unsigned OFF_SET    = 32'h08;
  localparam int unsigned OFF_CLEAR  = 32'h0C;
  localparam int unsigned OFF_MBOX   = 32'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLEAR,
    SEL_MBOX
  } sel_e;
endpackage

// File: rtl/ipi_bank_decode.sv
module ipi_bank_decode
  import ipi_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = $clog2(MBOX_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned MBOX_END = OFF_MBOX + 4 * MBOX_WORDS;

  logic [31:0]       a32;
  logic [ADDR_W-1:0] off;

  assign a32 = 32'(addr);
  assign off = addr - ADDR_W'(OFF_MBOX);
  assign idx = IDX_W'(off >> 2);

  always_comb begin
    sel = SEL_NONE;
    if (a32 == OFF_STATUS)      sel = SEL_STATUS;
    else if (a32 == OFF_ENABLE) sel = SEL_ENABLE;
    else if (a32 == OFF_SET)    sel = SEL_SET;
    else if (a32 == OFF_CLEAR)  sel = SEL_CLEAR;
    else if (a32 >= OFF_MBOX && a32 < MBOX_END && a32[1:0] == 2'b00)
      sel = SEL_MBOX;
  end
endmodule

// File: rtl/ipi_bank_core.sv
module ipi_bank_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] en_q,
  output logic              irq
);
  logic [DATA_W-1:0] status_nx;
  logic              irq_nx;

  always_comb begin
    status_nx = status_q;
    irq_nx    = irq;
    if (set_we) begin
      status_nx = status_q | wdata;
      if ((status_nx & en_q) != '0) irq_nx = 1'b1;
    end else if (clr_we) begin
      status_nx = status_q & ~wdata;
      if (status_nx == '0 && en_q != '0) irq_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_nx;
      irq      <= irq_nx;
      if (en_we) en_q <= wdata;
    end
  end
endmodule

// File: rtl/ipi_bank_mbox.sv
module ipi_bank_mbox #(
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = $clog2(MBOX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [MBOX_WORDS];

  for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         word_q <= '0;
      else if (we && idx == IDX_W'(w))    word_q <= wdata;
    end
    assign words[w] = word_q;
  end

  assign rdata = words[idx];
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
  import ipi_bank_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MBOX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_illegal,
  output logic              err_unimpl,
  output logic              irq
);
  localparam int IDX_W = $clog2(MBOX_WORDS);

  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic              acc;
  logic              wr;
  logic              rd;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] mbox_rdata;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;

  ipi_bank_decode #(.ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS)) u_dec (
    .addr (req_addr),
    .sel  (sel),
    .idx  (idx)
  );

  ipi_bank_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (wr && sel == SEL_SET),
    .clr_we   (wr && sel == SEL_CLEAR),
    .en_we    (wr && sel == SEL_ENABLE),
    .wdata    (req_wdata),
    .status_q (status_q),
    .en_q     (en_q),
    .irq      (irq)
  );

  ipi_bank_mbox #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr && sel == SEL_MBOX),
    .idx   (idx),
    .wdata (req_wdata),
    .rdata (mbox_rdata)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: rd_mux = status_q;
      SEL_ENABLE: rd_mux = en_q;
      SEL_MBOX:   rd_mux = mbox_rdata;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      err_illegal <= 1'b0;
      err_unimpl  <= 1'b0;
    end else begin
      if (rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      err_illegal <= wr && sel == SEL_STATUS;
      err_unimpl  <= acc && sel == SEL_NONE;
    end
  end
endmodule

// File: rtl/ipi_bank_chk.sv
module ipi_bank_chk
  import ipi_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] en_q,
  input logic              irq,
  input logic              err_illegal,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata
);
  logic w_set, w_clr, w_stat, w_en;
  assign w_set  = acc && req_write && req_addr == ADDR_W'(OFF_SET);
  assign w_clr  = acc && req_write && req_addr == ADDR_W'(OFF_CLEAR);
  assign w_stat = acc && req_write && req_addr == ADDR_W'(OFF_STATUS);
  assign w_en   = acc && req_write && req_addr == ADDR_W'(OFF_ENABLE);

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> status_q == ($past(status_q) | $past(req_wdata)));  // R2
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    w_set && ((status_q | req_wdata) & en_q) != '0 |=> irq);  // R3
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr && (status_q & ~req_wdata) == '0 && en_q != '0 |=> !irq);  // R4
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    w_stat |=> $stable(status_q) && err_illegal);  // R5
  AST_EN_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> $stable(irq));  // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));  // R10
  AST_REQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);  // R10
endmodule

bind ipi_bank ipi_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc         (acc),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .status_q    (status_q),
  .en_q        (en_q),
  .irq         (irq),
  .err_illegal (err_illegal),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata)
);

// File: tb/ipi_bank_tb.sv
`timescale 1ns/1ps
module ipi_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        err_illegal, err_unimpl, irq;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ipi_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .err_illegal(err_illegal), .err_unimpl(err_unimpl), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard on each response handshake
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected response", rsp_rdata, 32'hx);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(10 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    rd(8'h00, 32'h0, "R1 status");
    rd(8'h04, 32'h0, "R1 enable");
    for (int k = 0; k < 8; k++) rd(8'(8'h20 + 4 * k), 32'h0, "R1 mailbox");

    // R6 enable write/read, irq unchanged
    wr(8'h04, 32'h0000_00F0);
    chk("R6 irq after enable write", {31'd0, irq}, 32'd0);
    rd(8'h04, 32'h0000_00F0, "R6 enable readback");

    // R2/R3 masked set keeps irq low
    wr(8'h08, 32'h0000_0003);
    chk("R3 masked set irq", {31'd0, irq}, 32'd0);
    rd(8'h00, 32'h0000_0003, "R2 status after set");
    wr(8'h08, 32'h0000_0010);
    chk("R3 unmasked set irq", {31'd0, irq}, 32'd1);
    rd(8'h00, 32'h0000_0013, "R2 status OR");

    // R6 enable to zero does not drop irq
    wr(8'h04, 32'h0);
    chk("R6 irq held", {31'd0, irq}, 32'd1);

    // R5 status write ignored
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R5 err_illegal pulse", {31'd0, err_illegal}, 32'd1);
    @(negedge clk);
    chk("R5 err_illegal drops", {31'd0, err_illegal}, 32'd0);
    rd(8'h00, 32'h0000_0013, "R5 status unchanged");

    // R4 clear with enable zero leaves irq high
    wr(8'h0C, 32'h0000_0013);
    chk("R4 irq stays with zero enable", {31'd0, irq}, 32'd1);
    rd(8'h00, 32'h0, "R4 status cleared");
    wr(8'h04, 32'h0000_0001);
    wr(8'h08, 32'h0);
    chk("R3 empty set keeps irq", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h0);
    chk("R4 clear lowers irq", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h0000_0001);
    chk("R3 set raises irq", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h0000_0001);
    chk("R4 clear drops irq", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h0000_0005);
    wr(8'h0C, 32'h0000_0004);
    chk("R4 partial clear keeps irq", {31'd0, irq}, 32'd1);
    rd(8'h00, 32'h0000_0001, "R4 partial clear status");

    // R7 set/clear read zero
    rd(8'h08, 32'h0, "R7 set port read");
    rd(8'h0C, 32'h0, "R7 clear port read");

    // R8 mailbox
    for (int k = 0; k < 8; k++) wr(8'(8'h20 + 4 * k), 32'hA500_0000 | (32'h111 * k));
    for (int k = 7; k >= 0; k--) rd(8'(8'h20 + 4 * k), 32'hA500_0000 | (32'h111 * k), "R8 mailbox word");

    // R9 undecoded offsets
    wr(8'h40, 32'hDEAD_BEEF);
    chk("R9 err_unimpl write", {31'd0, err_unimpl}, 32'd1);
    wr(8'h22, 32'h1234_5678);
    chk("R9 err_unimpl misaligned", {31'd0, err_unimpl}, 32'd1);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R9 undecoded read");
    chk("R9 err_unimpl read", {31'd0, err_unimpl}, 32'd1);
    rd(8'h10, 32'h0, "R9 gap read");
    rd(8'h20, 32'hA500_0000, "R9 word0 untouched");
    rd(8'h3C, 32'hA500_0777, "R9 word7 untouched");
    rd(8'h00, 32'h0000_0001, "R9 status untouched");
    chk("R9 irq untouched", {31'd0, irq}, 32'd1);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(8'h04, 32'h0000_0001, "R10 held response");
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R10 req_ready low", {31'd0, req_ready}, 32'd0);
    held = rsp_rdata;
    repeat (2) @(negedge clk);
    chk("R10 data stable", rsp_rdata, held);
    chk("R10 still stalled", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 response retired", {31'd0, rsp_valid}, 32'd0);

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule